// File: doc/BRIEF.md
# USB IN Endpoint Bank Controller

This block buffers outgoing data for a single USB IN endpoint with one or two byte banks. Firmware fills the bank it currently owns through a byte-wide write port and watches three flags: a transmit-ready flag that can raise an interrupt, a bank-ownership flag, and a write-allowed flag. When firmware has filled a bank, it first clears the transmit-ready flag and then clears the ownership flag. This queues the bank for the USB side and, with two banks, moves firmware on to the other bank.

The USB side sees a simplified transaction interface. An IN-token pulse gets a registered answer one cycle later: DATA with the queued bank's byte count, or NAK when nothing is queued. The packet bytes are read by index from the queued bank. A host-ACK pulse frees that bank, which can then return to firmware. Banks are sent in the order they were queued.

Top module: `usb_in_bank_ctrl`

## Requirements
- R1: While reset is held, every flag and response output is 0. On the first clock edge after reset with `epEnable` high, `txReady` and `bankCtl` both become 1 (all banks free, both pointers on bank 0).
- R2: `epIrq` equals `txReady` AND `txIntEn` in every cycle.
- R3: A `txReadyClr` pulse while `txReady` is 1 makes `txReady` 0 on the next cycle and leaves `bankCtl` at 1.
- R4: A `bankCtlClr` pulse while `txReady` is still 1 has no effect: `bankCtl` stays 1 and no bank is queued.
- R5: A `bankCtlClr` pulse while `bankCtl` is 1 and `txReady` is 0 queues the current bank. In the same edge the firmware pointer moves to the next bank (it stays on bank 0 when NUM_BANKS is 1). `txReady` and `bankCtl` are then reloaded together: 1 if that bank is free and `epEnable` is high, else 0.
- R6: `rwAllowed` is 1 exactly while `bankCtl` is 1 and the current bank holds fewer than BANK_BYTES bytes. Writes beyond BANK_BYTES are dropped.
- R7: A write strobe (`cpuWrValid`) while `rwAllowed` is 0 stores nothing and does not advance the bank's byte count.
- R8: One cycle after `inToken`, `respValid` is 1. `respIsData` is 0 (NAK) with `pktLen` 0 if no bank is queued.
- R9: If a bank is queued, the response has `respIsData` 1 (DATA) and `pktLen` equal to that bank's byte count. `rdData` gives the byte written at position `rdAddr`, with the first byte written at index 0.
- R10: `hostAck` frees the queued bank and clears its count. Banks are sent in the order they were queued. A freed bank that the firmware pointer is on reloads both flags to 1.
- R11: A bank queued with no bytes is answered with DATA and `pktLen` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| epEnable | input | 1 | Endpoint enabled; allows banks to be offered to firmware |
| txIntEn | input | 1 | Interrupt enable for the transmit-ready flag |
| cpuWrValid | input | 1 | Firmware byte write strobe |
| cpuWrData | input | 8 | Firmware byte |
| txReadyClr | input | 1 | Firmware strobe clearing `txReady` |
| bankCtlClr | input | 1 | Firmware strobe clearing `bankCtl` (queues the bank) |
| txReady | output | 1 | Current bank is free for firmware |
| bankCtl | output | 1 | Firmware owns the current bank |
| rwAllowed | output | 1 | Firmware may write a byte now |
| epIrq | output | 1 | Endpoint interrupt |
| inToken | input | 1 | IN token received |
| respValid | output | 1 | Response to the previous cycle's token |
| respIsData | output | 1 | 1 = DATA, 0 = NAK |
| pktLen | output | $clog2(BANK_BYTES+1) | Byte count of the packet being answered |
| rdAddr | input | $clog2(BANK_BYTES) | Byte index into the queued bank |
| rdData | output | 8 | Byte of the queued bank at `rdAddr` |
| hostAck | input | 1 | Host acknowledged the packet |

## Verification
The properties assume that every input is a known level sampled once per clock, and that a strobe held for several cycles acts in each of them. They also assume `rdAddr` stays below BANK_BYTES and that `hostAck` may arrive at any time, since an acknowledge with nothing queued is ignored. The directed part of the stimulus drives one-cycle pulses in the legal order and also in the forbidden order. The random part draws every strobe independently each cycle, keeps `rdAddr` in range and holds `epEnable` high most of the time. A one-bank and a two-bank instance share the same stimulus.

// File: rtl/usb_in_bank_pkg.sv
package usb_in_bank_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;          // accepted firmware byte write into the firmware bank
    logic freeEn;        // queued bank released by host acknowledge
    logic tokenEn;       // IN token seen this cycle
    logic tokenHasData;  // a bank was queued when the token arrived
  } bankStrobe_t;

endpackage

// File: rtl/usb_in_bank_ctl.sv
module usb_in_bank_ctl
  import usb_in_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PTR_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epEnable,
  input  logic             txIntEn,
  input  logic             cpuWrValid,
  input  logic             txReadyClr,
  input  logic             bankCtlClr,
  input  logic             inToken,
  input  logic             hostAck,
  input  logic             curBankFull,
  output bankStrobe_t      strobe,
  output logic [PTR_W-1:0] cpuPtr,
  output logic [PTR_W-1:0] sendPtr,
  output logic             txReady,
  output logic             bankCtl,
  output logic             rwAllowed,
  output logic             epIrq,
  output logic             respValid,
  output logic             respIsData
);

  logic [NUM_BANKS-1:0] busyQ, busyD;
  logic [PTR_W-1:0]     cpuPtrQ, cpuPtrD, sendPtrQ, sendPtrD;
  logic                 txReadyQ, txReadyD, bankCtlQ, bankCtlD;
  logic                 respValidQ, respIsDataQ;
  logic                 commitEn, freeEn, wrEn, avail, rwOk;

  // Step a bank pointer; a single bank never moves
  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    if (NUM_BANKS == 1) return '0;
    return (p == PTR_W'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rwOk     = bankCtlQ && !curBankFull;
    wrEn     = cpuWrValid && rwOk;
    commitEn = bankCtlClr && bankCtlQ && !txReadyQ;
    freeEn   = hostAck && busyQ[sendPtrQ];

    busyD = busyQ;
    if (freeEn)   busyD[sendPtrQ] = 1'b0;
    if (commitEn) busyD[cpuPtrQ]  = 1'b1;

    sendPtrD = freeEn   ? advance(sendPtrQ) : sendPtrQ;
    cpuPtrD  = commitEn ? advance(cpuPtrQ)  : cpuPtrQ;
    avail    = epEnable && !busyD[cpuPtrD];

    txReadyD = txReadyQ && !txReadyClr;
    bankCtlD = bankCtlQ;
    if (commitEn) begin
      txReadyD = avail;
      bankCtlD = avail;
    end else if (!bankCtlQ && avail) begin
      txReadyD = 1'b1;
      bankCtlD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ       <= '0;
      cpuPtrQ     <= '0;
      sendPtrQ    <= '0;
      txReadyQ    <= 1'b0;
      bankCtlQ    <= 1'b0;
      respValidQ  <= 1'b0;
      respIsDataQ <= 1'b0;
    end else begin
      busyQ       <= busyD;
      cpuPtrQ     <= cpuPtrD;
      sendPtrQ    <= sendPtrD;
      txReadyQ    <= txReadyD;
      bankCtlQ    <= bankCtlD;
      respValidQ  <= inToken;
      respIsDataQ <= inToken && busyQ[sendPtrQ];
    end
  end

  assign strobe = '{wrEn: wrEn, freeEn: freeEn, tokenEn: inToken,
                    tokenHasData: busyQ[sendPtrQ]};
  assign cpuPtr     = cpuPtrQ;
  assign sendPtr    = sendPtrQ;
  assign txReady    = txReadyQ;
  assign bankCtl    = bankCtlQ;
  assign rwAllowed  = rwOk;
  assign epIrq      = txReadyQ && txIntEn;
  assign respValid  = respValidQ;
  assign respIsData = respIsDataQ;

endmodule

// File: rtl/usb_in_bank_data.sv
module usb_in_bank_data
  import usb_in_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  parameter int PTR_W      = 1,
  parameter int CNT_W      = 7,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobe_t       strobe,
  input  logic [PTR_W-1:0]  cpuPtr,
  input  logic [PTR_W-1:0]  sendPtr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              curBankFull,
  output logic [CNT_W-1:0]  pktLen,
  output logic [7:0]        rdData
);

  logic [CNT_W-1:0] bankCnt [NUM_BANKS];
  logic [7:0]       bankRd  [NUM_BANKS];
  logic [CNT_W-1:0] pktLenQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cntQ;
    logic [7:0]       store [BANK_BYTES];
    logic             wrHit, freeHit;

    assign wrHit   = strobe.wrEn   && (cpuPtr  == PTR_W'(b));
    assign freeHit = strobe.freeEn && (sendPtr == PTR_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n)       cntQ <= '0;
      else if (freeHit) cntQ <= '0;
      else if (wrHit)   cntQ <= cntQ + 1'b1;
    end

    // Byte storage carries no reset; the count marks valid entries
    always_ff @(posedge clk) begin
      if (wrHit) store[cntQ[ADDR_W-1:0]] <= wrData;
    end

    assign bankCnt[b] = cntQ;
    assign bankRd[b]  = store[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pktLenQ <= '0;
    else if (strobe.tokenEn) pktLenQ <= strobe.tokenHasData ? bankCnt[sendPtr] : '0;
  end

  assign curBankFull = (bankCnt[cpuPtr] == CNT_W'(BANK_BYTES));
  assign pktLen      = pktLenQ;
  assign rdData      = bankRd[sendPtr];

endmodule

// File: rtl/usb_in_bank_ctrl.sv
module usb_in_bank_ctrl
  import usb_in_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int CNT_W  = $clog2(BANK_BYTES + 1),
  localparam int ADDR_W = $clog2(BANK_BYTES),
  localparam int PTR_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              epEnable,
  input  logic              txIntEn,
  input  logic              cpuWrValid,
  input  logic [7:0]        cpuWrData,
  input  logic              txReadyClr,
  input  logic              bankCtlClr,
  output logic              txReady,
  output logic              bankCtl,
  output logic              rwAllowed,
  output logic              epIrq,
  input  logic              inToken,
  output logic              respValid,
  output logic              respIsData,
  output logic [CNT_W-1:0]  pktLen,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              hostAck
);

  bankStrobe_t      strobe;
  logic [PTR_W-1:0] cpuPtr, sendPtr;
  logic             curBankFull;

  usb_in_bank_ctl #(.NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .epEnable(epEnable), .txIntEn(txIntEn),
    .cpuWrValid(cpuWrValid), .txReadyClr(txReadyClr), .bankCtlClr(bankCtlClr),
    .inToken(inToken), .hostAck(hostAck), .curBankFull(curBankFull),
    .strobe(strobe), .cpuPtr(cpuPtr), .sendPtr(sendPtr),
    .txReady(txReady), .bankCtl(bankCtl), .rwAllowed(rwAllowed), .epIrq(epIrq),
    .respValid(respValid), .respIsData(respIsData)
  );

  usb_in_bank_data #(
    .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .PTR_W(PTR_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cpuPtr(cpuPtr), .sendPtr(sendPtr),
    .wrData(cpuWrData), .rdAddr(rdAddr), .curBankFull(curBankFull),
    .pktLen(pktLen), .rdData(rdData)
  );

endmodule

// File: rtl/usb_in_bank_chk.sv
module usb_in_bank_chk #(
  parameter int BANK_BYTES = 64,
  localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txIntEn,
  input logic             txReadyClr,
  input logic             bankCtlClr,
  input logic             txReady,
  input logic             bankCtl,
  input logic             rwAllowed,
  input logic             epIrq,
  input logic             inToken,
  input logic             respValid,
  input logic             respIsData,
  input logic [CNT_W-1:0] pktLen
);

  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epIrq == (txReady && txIntEn));

  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txReady && txReadyClr |=> !txReady && bankCtl);

  // R4
  clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bankCtl && txReady && bankCtlClr |=> bankCtl);

  // R5
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txReady |-> bankCtl);

  // R6
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rwAllowed |-> bankCtl);

  // R8
  token_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inToken |=> respValid);

  // R8
  nak_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid && !respIsData |-> pktLen == '0);

  // R8
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inToken |=> !respValid);

endmodule

bind usb_in_bank_ctrl usb_in_bank_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .txIntEn(txIntEn), .txReadyClr(txReadyClr),
  .bankCtlClr(bankCtlClr), .txReady(txReady), .bankCtl(bankCtl),
  .rwAllowed(rwAllowed), .epIrq(epIrq), .inToken(inToken),
  .respValid(respValid), .respIsData(respIsData), .pktLen(pktLen)
);

// File: tb/usb_in_bank_ctrl_bench.sv
`timescale 1ns/1ps
module usb_in_bank_ctrl_bench;

  localparam int BB = 64;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epEnable = 1'b1, txIntEn = 1'b0, cpuWrValid = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic txReadyClr = 1'b0, bankCtlClr = 1'b0, inToken = 1'b0, hostAck = 1'b0;
  logic [5:0] rdAddr = 6'd0;

  logic       txReadyO [2];
  logic       bankCtlO [2];
  logic       rwO      [2];
  logic       irqO     [2];
  logic       rvO      [2];
  logic       rdO      [2];
  logic [6:0] lenO     [2];
  logic [7:0] dataO    [2];

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_in_bank_ctrl #(.NUM_BANKS(2), .BANK_BYTES(BB)) u_usb_in_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .epEnable(epEnable), .txIntEn(txIntEn),
    .cpuWrValid(cpuWrValid), .cpuWrData(cpuWrData), .txReadyClr(txReadyClr),
    .bankCtlClr(bankCtlClr), .txReady(txReadyO[0]), .bankCtl(bankCtlO[0]),
    .rwAllowed(rwO[0]), .epIrq(irqO[0]), .inToken(inToken), .respValid(rvO[0]),
    .respIsData(rdO[0]), .pktLen(lenO[0]), .rdAddr(rdAddr), .rdData(dataO[0]),
    .hostAck(hostAck));

  usb_in_bank_ctrl #(.NUM_BANKS(1), .BANK_BYTES(BB)) u_usb_in_bank_ctrl_single (
    .clk(clk), .rst_n(rst_n), .epEnable(epEnable), .txIntEn(txIntEn),
    .cpuWrValid(cpuWrValid), .cpuWrData(cpuWrData), .txReadyClr(txReadyClr),
    .bankCtlClr(bankCtlClr), .txReady(txReadyO[1]), .bankCtl(bankCtlO[1]),
    .rwAllowed(rwO[1]), .epIrq(irqO[1]), .inToken(inToken), .respValid(rvO[1]),
    .respIsData(rdO[1]), .pktLen(lenO[1]), .rdAddr(rdAddr), .rdData(dataO[1]),
    .hostAck(hostAck));

  // Behavioural reference: per instance, bank queue state
  int  nb [2] = '{2, 1};
  bit  mBusy [2][2];
  int  mCnt  [2][2];
  byte mMem  [2][2][BB];
  int  mCp [2], mSp [2], mLen [2];
  bit  mTx [2], mBc [2], mRv [2], mRd [2];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int b = 0; b < 2; b++) begin mBusy[d][b] = 0; mCnt[d][b] = 0; end
        mCp[d] = 0; mSp[d] = 0; mTx[d] = 0; mBc[d] = 0;
        mRv[d] = 0; mRd[d] = 0; mLen[d] = 0;
      end else begin
        int cp, sp;
        bit acc, com, ack, av;
        cp = mCp[d]; sp = mSp[d];
        acc = cpuWrValid && mBc[d] && (mCnt[d][cp] < BB);
        com = bankCtlClr && mBc[d] && !mTx[d];
        ack = hostAck && mBusy[d][sp];
        mRv[d] = inToken;
        mRd[d] = inToken && mBusy[d][sp];
        if (inToken) mLen[d] = mBusy[d][sp] ? mCnt[d][sp] : 0;
        if (acc) begin
          mMem[d][cp][mCnt[d][cp]] = cpuWrData;
          mCnt[d][cp]++;
        end
        if (ack) begin
          mBusy[d][sp] = 0; mCnt[d][sp] = 0; mSp[d] = (sp + 1) % nb[d];
        end
        if (com) begin
          mBusy[d][cp] = 1; mCp[d] = (cp + 1) % nb[d];
        end
        if (txReadyClr) mTx[d] = 0;
        av = epEnable && !mBusy[d][mCp[d]];
        if (com) begin mTx[d] = av; mBc[d] = av; end
        else if (!mBc[d] && av) begin mTx[d] = 1; mBc[d] = 1; end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int d = 0; d < 2; d++) begin
        int sp;
        bit rwExp;
        sp = mSp[d];
        rwExp = mBc[d] && (mCnt[d][mCp[d]] < BB);
        check(txReadyO[d] == mTx[d], "R3", "txReady", txReadyO[d], mTx[d]);
        check(bankCtlO[d] == mBc[d], "R5", "bankCtl", bankCtlO[d], mBc[d]);
        check(rwO[d] == rwExp, "R6", "rwAllowed", rwO[d], rwExp);
        check(irqO[d] == (mTx[d] && txIntEn), "R2", "epIrq", irqO[d], mTx[d] && txIntEn);
        check(rvO[d] == mRv[d], "R8", "respValid", rvO[d], mRv[d]);
        check(rdO[d] == mRd[d], "R9", "respIsData", rdO[d], mRd[d]);
        check(int'(lenO[d]) == mLen[d], "R9", "pktLen", lenO[d], mLen[d]);
        if (mBusy[d][sp] && int'(rdAddr) < mCnt[d][sp])
          check(dataO[d] == mMem[d][sp][rdAddr], "R9", "rdData",
                dataO[d], mMem[d][sp][rdAddr]);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic wrByte(input logic [7:0] b);
    cpuWrValid = 1'b1; cpuWrData = b; cyc(); cpuWrValid = 1'b0;
  endtask

  task automatic pulseReadyClr(); txReadyClr = 1'b1; cyc(); txReadyClr = 1'b0; endtask
  task automatic pulseBankClr();  bankCtlClr = 1'b1; cyc(); bankCtlClr = 1'b0; endtask
  task automatic pulseToken();    inToken = 1'b1;    cyc(); inToken = 1'b0;    endtask
  task automatic pulseAck();      hostAck = 1'b1;    cyc(); hostAck = 1'b0;    endtask

  task automatic commit();
    pulseReadyClr(); pulseBankClr();
  endtask

  initial begin
    #1;
    repeat (3) cyc();
    sample();
    // R1 reset state
    check(txReadyO[0] == 0 && bankCtlO[0] == 0 && rvO[0] == 0, "R1", "flags in reset",
          {txReadyO[0], bankCtlO[0], rvO[0]}, 0);
    rst_n = 1'b1;
    cyc(); sample();
    check(txReadyO[0] && bankCtlO[0], "R1", "flags after reset", {txReadyO[0], bankCtlO[0]}, 3);
    check(txReadyO[1] && bankCtlO[1], "R1", "single flags after reset",
          {txReadyO[1], bankCtlO[1]}, 3);

    // R8 token with nothing queued
    pulseToken(); sample();
    check(rvO[0] && !rdO[0] && lenO[0] == 0, "R8", "NAK response", {rvO[0], rdO[0]}, 2);

    // R2 interrupt follows enable
    txIntEn = 1'b1; #1; sample();
    check(irqO[0] == 1, "R2", "epIrq enabled", irqO[0], 1);

    for (int i = 0; i < 5; i++) wrByte(8'hA0 + 8'(i));

    // R4 ownership clear before ready clear is ignored
    pulseBankClr(); sample();
    check(bankCtlO[0] == 1 && bankCtlO[1] == 1, "R4", "bankCtl kept",
          {bankCtlO[0], bankCtlO[1]}, 3);

    // R3 ready clear
    pulseReadyClr(); sample();
    check(txReadyO[0] == 0 && bankCtlO[0] == 1, "R3", "txReady cleared",
          {txReadyO[0], bankCtlO[0]}, 1);
    check(irqO[0] == 0, "R2", "epIrq dropped", irqO[0], 0);

    // R5 queue the bank
    pulseBankClr(); sample();
    check(txReadyO[0] && bankCtlO[0], "R5", "two banks reload", {txReadyO[0], bankCtlO[0]}, 3);
    check(!txReadyO[1] && !bankCtlO[1], "R5", "one bank stays low",
          {txReadyO[1], bankCtlO[1]}, 0);
    txIntEn = 1'b0;

    // R7 single instance drops these; two-bank instance stores them
    wrByte(8'h51); wrByte(8'h52);

    // R9 data response
    pulseToken(); sample();
    check(rdO[0] && lenO[0] == 5, "R9", "DATA length", lenO[0], 5);
    check(rdO[1] && lenO[1] == 5, "R9", "single DATA length", lenO[1], 5);
    rdAddr = 6'd3; #1;
    check(dataO[0] == 8'hA3, "R9", "byte 3", dataO[0], 8'hA3);
    for (int i = 0; i < 5; i++) begin rdAddr = 6'(i); cyc(); end

    // R10 ack frees bank; single returns to firmware
    pulseAck(); sample();
    check(txReadyO[1] && bankCtlO[1], "R10", "single reload", {txReadyO[1], bankCtlO[1]}, 3);
    pulseToken(); sample();
    check(rvO[0] && !rdO[0], "R8", "NAK after ack", rdO[0], 0);

    commit();
    pulseToken(); sample();
    check(rdO[0] && lenO[0] == 2, "R10", "second bank length", lenO[0], 2);
    check(rdO[1] && lenO[1] == 0, "R11", "zero-length packet", lenO[1], 0);
    check(lenO[1] == 0, "R7", "dropped writes not counted", lenO[1], 0);
    pulseAck();

    // R6 fill past capacity
    for (int i = 0; i < BB + 3; i++) wrByte(8'(i * 3));
    sample();
    check(rwO[0] == 0 && rwO[1] == 0, "R6", "rwAllowed low when full", {rwO[0], rwO[1]}, 0);
    commit();
    pulseToken(); sample();
    check(lenO[0] == 7'(BB), "R6", "full length", lenO[0], BB);
    for (int i = 0; i < BB; i += 7) begin rdAddr = 6'(i); cyc(); end
    pulseAck();

    // R10 ordering with both banks queued
    wrByte(8'h11); wrByte(8'h12); wrByte(8'h13);
    commit();
    wrByte(8'h21);
    commit(); sample();
    check(!bankCtlO[0] && !rwO[0], "R7", "both banks queued", {bankCtlO[0], rwO[0]}, 0);
    wrByte(8'hEE); wrByte(8'hEF);
    pulseToken(); sample();
    check(lenO[0] == 3, "R10", "first queued first sent", lenO[0], 3);
    pulseAck(); sample();
    check(txReadyO[0] && bankCtlO[0], "R10", "freed bank reloads", {txReadyO[0], bankCtlO[0]}, 3);
    pulseToken(); sample();
    check(lenO[0] == 1, "R7", "later bank unaffected by dropped writes", lenO[0], 1);
    rdAddr = 6'd0; #1;
    check(dataO[0] == 8'h21, "R10", "later bank byte", dataO[0], 8'h21);
    pulseAck();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      epEnable   = ($urandom_range(0, 19) != 0);
      txIntEn    = $urandom_range(0, 1) == 1;
      cpuWrValid = $urandom_range(0, 2) != 0;
      cpuWrData  = 8'($urandom);
      txReadyClr = $urandom_range(0, 5) == 0;
      bankCtlClr = $urandom_range(0, 5) == 0;
      inToken    = $urandom_range(0, 4) == 0;
      hostAck    = $urandom_range(0, 6) == 0;
      rdAddr     = 6'($urandom_range(0, BB - 1));
      cyc();
    end
    cpuWrValid = 0; txReadyClr = 0; bankCtlClr = 0; inToken = 0; hostAck = 0;
    cyc(); sample();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule